// File: doc/BRIEF.md
# Five-Stage Pipelined Register-Move Core

This block is a small in-order processor core with five pipeline stages: fetch, decode, execute, memory and writeback. It runs a subset of a 64-bit register machine: halt, nop, a load of an immediate into a register, a register-to-register copy, four ALU operations (add, subtract, and, xor) and conditional copies. Every instruction passes through all five pipeline registers, including those that do nothing in execute or memory. Operand hazards are resolved by forwarding the newest in-flight result into decode, so the core never stalls for data.

The core fetches up to ten bytes at a time from an instruction port. It reports a three-bit machine status. When fetch decodes a halt, an unknown opcode or a port error, the program counter freezes. The faulting instruction keeps moving down the pipeline, and the status output changes only when that instruction reaches writeback. A read-only port exposes the register file, so a test can compare final register contents.

Top module: `pipe5_core`

## Requirements
- R1: Byte 0 carries the opcode in bits 7:4 and the function in bits 3:0. Byte 1 carries the first register id in bits 7:4 and the second in bits 3:0. Opcodes are halt=0x0 and nop=0x1 (1 byte), move/conditional move=0x2 and ALU=0x6 (2 bytes), and immediate load=0x3 (10 bytes, destination in the second id, 64-bit constant in bytes 2..9 little-endian). While the fetch status is AOK, the next fetch address is the current one plus the instruction length.
- R2: Status codes are AOK=1, HLT=2, ADR=3, INS=4, and register id 0xF means none. After reset the status output is AOK, the fetch address is 0 and all fifteen registers read 0.
- R3: A non-AOK fetch status holds the fetch address, so no byte past a halt is ever fetched as an instruction start.
- R4: A non-AOK status reaches the status output only after its instruction has passed through every pipeline register. A run of N cycles shows non-AOK after N-1 clock edges from reset release: a lone halt takes 5 cycles, and three nops then halt take 8.
- R5: An opcode outside the set in R1 (or an out-of-range function) gives status INS, writes no register, and with a nop ahead of it finishes in 6 cycles.
- R6: An asserted fetch error gives status ADR through the same drain as R4.
- R7: An immediate load writes its constant, and a move copies a register. A load followed by a move takes 7 cycles.
- R8: A decode operand takes the result of the youngest older instruction that writes that register (execute, then memory, then writeback, then the register file), so back-to-back dependent instructions need no stall.
- R9: ALU function 0 adds, 1 subtracts the first register from the second, 2 ands, 3 xors. The result goes to the second register.
- R10: Only ALU instructions update the flags. The flags are zero, sign and signed overflow of the result, and they reset to zero=1, sign=0, overflow=0.
- R11: A conditional move with function 1..6 (le, lt, eq, ne, ge, gt, from the flags) writes its destination only when its condition holds. Function 0 always writes.
- R12: Once the status output is non-AOK it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | AW | Fetch address (program counter) |
| imem_bytes | input | 80 | Ten instruction bytes starting at imem_addr, byte 0 in bits 7:0 |
| imem_err | input | 1 | Fetch address is invalid |
| dbg_sel | input | 4 | Register id to observe |
| dbg_val | output | 64 | Current contents of register dbg_sel (0 for id 0xF) |
| stat | output | 3 | Machine status taken from the writeback stage |

## Verification
Short programs are loaded and run until the status leaves AOK. Then the cycle count, the final status, the highest fetched address and the register contents are compared. Lone halts, nop runs and an unknown opcode pin down the drain timing and the fetch freeze. Chains of immediate loads and moves whose sources sit one, two and three stages back separate the forwarding priorities. ALU sequences with and without signed overflow, followed by conditional moves of every flavour, separate flag generation from condition decoding. A program with no halt runs off the end of instruction memory to exercise the address-error path.

// File: rtl/p5_pkg.sv
package p5_pkg;
  localparam int XLEN = 64;
  localparam logic [3:0] RNONE = 4'hF;

  localparam logic [2:0] ST_AOK = 3'd1;
  localparam logic [2:0] ST_HLT = 3'd2;
  localparam logic [2:0] ST_ADR = 3'd3;
  localparam logic [2:0] ST_INS = 3'd4;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_MOVE  = 4'h2;
  localparam logic [3:0] OP_LOADI = 4'h3;
  localparam logic [3:0] OP_ALU   = 4'h6;

  // flags packed as {zero, sign, overflow}
  localparam logic [2:0] CC_RESET = 3'b100;

  typedef struct packed {
    logic [2:0]      stat;
    logic [3:0]      icode;
    logic [3:0]      ifun;
    logic [3:0]      ra;
    logic [3:0]      rb;
    logic [XLEN-1:0] valc;
  } dreg_t;

  typedef struct packed {
    logic [2:0]      stat;
    logic [3:0]      icode;
    logic [3:0]      ifun;
    logic [XLEN-1:0] vala;
    logic [XLEN-1:0] valb;
    logic [XLEN-1:0] valc;
    logic [3:0]      dst;
  } ereg_t;

  typedef struct packed {
    logic [2:0]      stat;
    logic [XLEN-1:0] vale;
    logic [3:0]      dst;
  } wreg_t;

  function automatic logic [3:0] ins_len(input logic [3:0] icode);
    case (icode)
      OP_MOVE, OP_ALU: ins_len = 4'd2;
      OP_LOADI:        ins_len = 4'd10;
      default:         ins_len = 4'd1;
    endcase
  endfunction

  function automatic logic ins_ok(input logic [3:0] icode, input logic [3:0] ifun);
    case (icode)
      OP_HALT, OP_NOP, OP_LOADI: ins_ok = (ifun == 4'h0);
      OP_MOVE:                   ins_ok = (ifun <= 4'h6);
      OP_ALU:                    ins_ok = (ifun <= 4'h3);
      default:                   ins_ok = 1'b0;
    endcase
  endfunction

  // result = b (op) a
  function automatic logic [XLEN-1:0] alu_calc(input logic [3:0] fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (fn)
      4'h0:    alu_calc = b + a;
      4'h1:    alu_calc = b - a;
      4'h2:    alu_calc = b & a;
      default: alu_calc = b ^ a;
    endcase
  endfunction

  function automatic logic [2:0] alu_flags(input logic [3:0] fn,
                                           input logic [XLEN-1:0] a,
                                           input logic [XLEN-1:0] b,
                                           input logic [XLEN-1:0] r);
    logic ovf;
    case (fn)
      4'h0:    ovf = (a[XLEN-1] == b[XLEN-1]) && (r[XLEN-1] != a[XLEN-1]);
      4'h1:    ovf = (a[XLEN-1] != b[XLEN-1]) && (r[XLEN-1] != b[XLEN-1]);
      default: ovf = 1'b0;
    endcase
    alu_flags = {(r == '0), r[XLEN-1], ovf};
  endfunction

  function automatic logic cond_ok(input logic [3:0] fn, input logic [2:0] cc);
    logic zf, lt;
    zf = cc[2];
    lt = cc[1] ^ cc[0];
    case (fn)
      4'h1:    cond_ok = lt | zf;
      4'h2:    cond_ok = lt;
      4'h3:    cond_ok = zf;
      4'h4:    cond_ok = ~zf;
      4'h5:    cond_ok = ~lt;
      4'h6:    cond_ok = ~lt & ~zf;
      default: cond_ok = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/p5_fetch.sv
module p5_fetch #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [79:0]   bytes,
  input  logic          err,
  output logic [3:0]    icode,
  output logic [3:0]    ifun,
  output logic [3:0]    ra,
  output logic [3:0]    rb,
  output logic [63:0]   valc,
  output logic [3:0]    len,
  output logic [AW-1:0] valp,
  output logic [2:0]    fstat
);
  import p5_pkg::*;

  always_comb begin
    icode = bytes[7:4];
    ifun  = bytes[3:0];
    ra    = bytes[15:12];
    rb    = bytes[11:8];
    valc  = bytes[79:16];
    len   = ins_len(icode);
    valp  = pc + {{(AW-4){1'b0}}, len};
    if (err)                      fstat = ST_ADR;
    else if (!ins_ok(icode, ifun)) fstat = ST_INS;
    else if (icode == OP_HALT)    fstat = ST_HLT;
    else                          fstat = ST_AOK;
  end
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int NREG = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_a,
  input  logic [3:0]  rd_b,
  output logic [63:0] q_a,
  output logic [63:0] q_b,
  input  logic        we,
  input  logic [3:0]  wa,
  input  logic [63:0] wd,
  input  logic [3:0]  dbg_sel,
  output logic [63:0] dbg_val
);
  logic [63:0] regs [NREG];

  function automatic logic [63:0] rd(input logic [3:0] id, input logic [63:0] v);
    rd = (32'(id) < NREG) ? v : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (32'(wa) < NREG)) begin
      regs[wa] <= wd;
    end
  end

  always_comb begin
    q_a     = rd(rd_a, regs[rd_a]);
    q_b     = rd(rd_b, regs[rd_b]);
    dbg_val = rd(dbg_sel, regs[dbg_sel]);
  end
endmodule

// File: rtl/p5_fwd.sv
module p5_fwd (
  input  logic [1:0][3:0]  src,
  input  logic [1:0][63:0] rf_val,
  input  logic [3:0]       e_dst,
  input  logic [63:0]      e_val,
  input  logic [3:0]       m_dst,
  input  logic [63:0]      m_val,
  input  logic [3:0]       w_dst,
  input  logic [63:0]      w_val,
  output logic [1:0][63:0] opnd
);
  import p5_pkg::*;

  for (genvar g = 0; g < 2; g++) begin : g_port
    always_comb begin
      if (src[g] == RNONE)      opnd[g] = rf_val[g];
      else if (src[g] == e_dst) opnd[g] = e_val;
      else if (src[g] == m_dst) opnd[g] = m_val;
      else if (src[g] == w_dst) opnd[g] = w_val;
      else                      opnd[g] = rf_val[g];
    end
  end
endmodule

// File: rtl/p5_exec.sv
module p5_exec (
  input  logic         clk,
  input  logic         rst_n,
  input  p5_pkg::ereg_t e,
  output logic [63:0]  vale,
  output logic [3:0]   dst,
  output logic         alu_act,
  output logic [2:0]   cc
);
  import p5_pkg::*;

  logic [63:0] alu_r;
  logic        take;

  always_comb begin
    alu_r   = alu_calc(e.ifun, e.vala, e.valb);
    alu_act = (e.icode == OP_ALU) && (e.stat == ST_AOK);
    take    = cond_ok(e.ifun, cc);
    case (e.icode)
      OP_ALU:   vale = alu_r;
      OP_MOVE:  vale = e.vala;
      OP_LOADI: vale = e.valc;
      default:  vale = '0;
    endcase
    dst = (e.icode == OP_MOVE && !take) ? RNONE : e.dst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cc <= CC_RESET;
    else if (alu_act) cc <= alu_flags(e.ifun, e.vala, e.valb, alu_r);
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int AW   = 16,
  parameter int NREG = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [79:0]   imem_bytes,
  input  logic          imem_err,
  input  logic [3:0]    dbg_sel,
  output logic [63:0]   dbg_val,
  output logic [2:0]    stat
);
  import p5_pkg::*;

  logic [AW-1:0] pc;
  dreg_t d_q;
  ereg_t e_q;
  wreg_t m_q, w_q;

  logic [3:0]  f_icode, f_ifun, f_ra, f_rb, f_len;
  logic [63:0] f_valc;
  logic [AW-1:0] f_valp;
  logic [2:0]  f_stat;

  p5_fetch #(.AW(AW)) u_fetch (
    .pc(pc), .bytes(imem_bytes), .err(imem_err),
    .icode(f_icode), .ifun(f_ifun), .ra(f_ra), .rb(f_rb),
    .valc(f_valc), .len(f_len), .valp(f_valp), .fstat(f_stat)
  );

  // decode
  logic [3:0] d_srca, d_srcb, d_dst;
  always_comb begin
    d_srca = (d_q.icode == OP_MOVE || d_q.icode == OP_ALU) ? d_q.ra : RNONE;
    d_srcb = (d_q.icode == OP_ALU) ? d_q.rb : RNONE;
    d_dst  = (d_q.icode == OP_MOVE || d_q.icode == OP_ALU ||
              d_q.icode == OP_LOADI) ? d_q.rb : RNONE;
    if (d_q.stat != ST_AOK) begin
      d_srca = RNONE;
      d_srcb = RNONE;
      d_dst  = RNONE;
    end
  end

  logic [63:0] rf_a, rf_b;
  logic        wb_we;
  logic [2:0]  w_stat;
  assign wb_we  = (w_q.dst != RNONE);
  assign w_stat = w_q.stat;

  p5_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a(d_srca), .rd_b(d_srcb), .q_a(rf_a), .q_b(rf_b),
    .we(wb_we), .wa(w_q.dst), .wd(w_q.vale),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val)
  );

  logic [63:0] e_vale;
  logic [3:0]  e_dst;
  logic        e_is_alu;
  logic [2:0]  cc;

  p5_exec u_exec (
    .clk(clk), .rst_n(rst_n), .e(e_q),
    .vale(e_vale), .dst(e_dst), .alu_act(e_is_alu), .cc(cc)
  );

  logic [1:0][63:0] opnd;
  p5_fwd u_fwd (
    .src({d_srcb, d_srca}), .rf_val({rf_b, rf_a}),
    .e_dst(e_dst), .e_val(e_vale),
    .m_dst(m_q.dst), .m_val(m_q.vale),
    .w_dst(w_q.dst), .w_val(w_q.vale),
    .opnd(opnd)
  );

  localparam dreg_t D_IDLE = '{stat: ST_AOK, icode: OP_NOP, ifun: 4'h0,
                                ra: RNONE, rb: RNONE, valc: '0};
  localparam ereg_t E_IDLE = '{stat: ST_AOK, icode: OP_NOP, ifun: 4'h0,
                                vala: '0, valb: '0, valc: '0, dst: RNONE};
  localparam wreg_t W_IDLE = '{stat: ST_AOK, vale: '0, dst: RNONE};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      d_q <= D_IDLE;
      e_q <= E_IDLE;
      m_q <= W_IDLE;
      w_q <= W_IDLE;
    end else begin
      if (f_stat == ST_AOK) pc <= f_valp;
      d_q <= '{stat: f_stat, icode: f_icode, ifun: f_ifun,
               ra: f_ra, rb: f_rb, valc: f_valc};
      e_q <= '{stat: d_q.stat, icode: d_q.icode, ifun: d_q.ifun,
               vala: opnd[0], valb: opnd[1], valc: d_q.valc, dst: d_dst};
      m_q <= '{stat: e_q.stat, vale: e_vale, dst: e_dst};
      w_q <= m_q;
    end
  end

  assign imem_addr = pc;
  assign stat      = w_q.stat;
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] imem_addr,
  input logic [2:0]    stat,
  input logic [2:0]    f_stat,
  input logic [3:0]    f_len,
  input logic          e_is_alu,
  input logic [2:0]    cc,
  input logic          wb_we,
  input logic [2:0]    w_stat
);
  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_stat == 3'd1) |=> (imem_addr == $past(imem_addr) + {{(AW-4){1'b0}}, $past(f_len)}));

  // R3
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_stat != 3'd1) |=> $stable(imem_addr));

  // R12
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat != 3'd1) |=> (stat == $past(stat)));

  // R10
  cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !e_is_alu |=> $stable(cc));

  // R5
  no_bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (w_stat == 3'd1));

  // R2
  stat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat >= 3'd1) && (stat <= 3'd4));
endmodule

bind pipe5_core pipe5_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .stat(stat),
  .f_stat(f_stat), .f_len(f_len), .e_is_alu(e_is_alu), .cc(cc),
  .wb_we(wb_we), .w_stat(w_stat)
);

// File: tb/sim_pipe5_core.sv
module sim_pipe5_core;
  localparam int PERIOD = 10;
  localparam int AW     = 16;
  localparam int MEMSZ  = 256;
  localparam int LIMIT  = 2000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [79:0]   imem_bytes;
  logic          imem_err;
  logic [3:0]    dbg_sel = 4'h0;
  logic [63:0]   dbg_val;
  logic [2:0]    stat;

  pipe5_core #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_bytes(imem_bytes),
    .imem_err(imem_err), .dbg_sel(dbg_sel), .dbg_val(dbg_val), .stat(stat)
  );

  always #(PERIOD/2) clk = ~clk;

  logic [7:0] mem [MEMSZ];
  always_comb begin
    for (int i = 0; i < 10; i++) begin
      int a;
      a = int'(imem_addr) + i;
      imem_bytes[i*8 +: 8] = (a < MEMSZ) ? mem[a] : 8'h00;
    end
    imem_err = (int'(imem_addr) >= MEMSZ);
  end

  // scoreboard
  typedef struct {
    string       req;
    int          kind;   // 0 cycles, 1 status, 2 register, 3 max fetch addr, 4 status held
    int          sel;
    logic [63:0] val;
  } exp_t;
  exp_t exp_q[$];

  int nchk = 0, nfail = 0;
  int wp, run_cycles, max_addr;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic put(input logic [7:0] x);
    mem[wp] = x;
    wp++;
  endtask
  task automatic irm(input logic [3:0] rb, input logic [63:0] v);
    put(8'h30); put({4'hF, rb});
    for (int k = 0; k < 8; k++) put(v[k*8 +: 8]);
  endtask
  task automatic two(input logic [3:0] op, input logic [3:0] fn,
                     input logic [3:0] ra, input logic [3:0] rb);
    put({op, fn}); put({ra, rb});
  endtask
  task automatic clear_prog(input logic [7:0] fill);
    for (int i = 0; i < MEMSZ; i++) mem[i] = fill;
    wp = 0;
  endtask
  task automatic push(input string req, input int kind, input int sel, input logic [63:0] v);
    exp_t e;
    e.req = req; e.kind = kind; e.sel = sel; e.val = v;
    exp_q.push_back(e);
  endtask

  // driver: reset, run until status leaves AOK
  task automatic run_prog();
    bit done;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    max_addr = int'(imem_addr);
    done = 1'b0;
    run_cycles = 0;
    while (!done && run_cycles < LIMIT) begin
      @(posedge clk);
      run_cycles++;
      @(negedge clk);
      if (int'(imem_addr) > max_addr) max_addr = int'(imem_addr);
      if (stat != 3'd1) done = 1'b1;
    end
    run_cycles++;
  endtask

  // monitor: pop expectations and compare against the design
  task automatic monitor();
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      case (e.kind)
        0: chk(e.req, "cycles", 64'(run_cycles), e.val);
        1: chk(e.req, "status", 64'(stat), e.val);
        2: begin
          dbg_sel = e.sel[3:0];
          #1;
          chk(e.req, $sformatf("reg %0d", e.sel), dbg_val, e.val);
        end
        3: chk(e.req, "max fetch addr", 64'(max_addr), e.val);
        default: begin
          repeat (3) @(negedge clk);
          chk(e.req, "status held", 64'(stat), e.val);
        end
      endcase
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R2 reset state
    clear_prog(8'h00);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2", "reset status", 64'(stat), 64'd1);
    chk("R2", "reset addr", 64'(imem_addr), 64'd0);
    for (int r = 0; r < 15; r++) begin
      dbg_sel = 4'(r);
      #1;
      chk("R2", "reset reg", dbg_val, 64'd0);
    end

    // lone halt
    clear_prog(8'h00);
    put(8'h00);
    push("R4", 0, 0, 5); push("R4", 1, 0, 2); push("R3", 3, 0, 0);
    push("R12", 4, 0, 2);
    run_prog(); monitor();

    // three nops then halt, nop after halt
    clear_prog(8'h00);
    put(8'h10); put(8'h10); put(8'h10); put(8'h00); put(8'h10);
    push("R4", 0, 0, 8); push("R3", 3, 0, 3); push("R4", 1, 0, 2);
    run_prog(); monitor();

    // nop, unknown opcode, halt
    clear_prog(8'h00);
    put(8'h10); put(8'hC0); put(8'hF8);
    for (int k = 0; k < 8; k++) put(8'h01);
    put(8'h00);
    push("R5", 0, 0, 6); push("R5", 1, 0, 4); push("R5", 2, 8, 0);
    push("R5", 3, 0, 1); push("R12", 4, 0, 4);
    run_prog(); monitor();

    // load then move
    clear_prog(8'h00);
    irm(4'h0, 64'd1); two(4'h2, 4'h0, 4'h0, 4'h3);
    push("R7", 0, 0, 7); push("R7", 2, 0, 1); push("R7", 2, 3, 1);
    run_prog(); monitor();

    // moves with forwarding from execute and memory
    clear_prog(8'h00);
    irm(4'h0, 64'h162e); irm(4'h1, 64'h22);
    two(4'h2, 4'h0, 4'h0, 4'h2); two(4'h2, 4'h0, 4'h1, 4'h0);
    push("R1", 3, 0, 24); push("R8", 0, 0, 9);
    push("R8", 2, 0, 64'h22); push("R8", 2, 1, 64'h22); push("R8", 2, 2, 64'h162e);
    run_prog(); monitor();

    // forwarding priority: youngest writer wins
    clear_prog(8'h00);
    irm(4'h0, 64'd1); irm(4'h3, 64'd2); irm(4'h1, 64'd3);
    two(4'h2, 4'h0, 4'h0, 4'h2); two(4'h2, 4'h0, 4'h1, 4'h3);
    two(4'h2, 4'h0, 4'h3, 4'h6); two(4'h2, 4'h0, 4'h3, 4'h7);
    push("R8", 0, 0, 12); push("R8", 2, 2, 1); push("R8", 2, 3, 3);
    push("R8", 2, 6, 3); push("R8", 2, 7, 3);
    run_prog(); monitor();

    // ALU operations
    clear_prog(8'h00);
    irm(4'h2, 64'd7); irm(4'h1, 64'd3);
    two(4'h6, 4'h0, 4'h1, 4'h3); two(4'h6, 4'h1, 4'h2, 4'h1);
    two(4'h6, 4'h2, 4'h2, 4'h3); two(4'h6, 4'h3, 4'h1, 4'h2);
    two(4'h6, 4'h2, 4'h2, 4'h6);
    push("R9", 0, 0, 12); push("R9", 2, 0, 0);
    push("R9", 2, 1, 64'hfffffffffffffffc); push("R9", 2, 2, 64'hfffffffffffffffb);
    push("R9", 2, 3, 3); push("R9", 2, 6, 0);
    run_prog(); monitor();

    // conditional moves under several flag states
    clear_prog(8'h00);
    irm(4'h3, 64'hace); irm(4'h0, 64'd1); two(4'h6, 4'h2, 4'h0, 4'h0);
    two(4'h2, 4'h6, 4'h3, 4'h1); two(4'h2, 4'h3, 4'h3, 4'h2);
    irm(4'h0, 64'hffffffffffffffff); two(4'h6, 4'h2, 4'h0, 4'h0);
    two(4'h2, 4'h2, 4'h3, 4'h4); two(4'h2, 4'h5, 4'h3, 4'h5);
    two(4'h6, 4'h3, 4'h0, 4'h0);
    two(4'h2, 4'h1, 4'h3, 4'h6); two(4'h2, 4'h4, 4'h3, 4'h7);
    push("R11", 0, 0, 17); push("R11", 2, 0, 0);
    push("R11", 2, 1, 64'hace); push("R11", 2, 2, 0); push("R11", 2, 4, 64'hace);
    push("R11", 2, 5, 0); push("R11", 2, 6, 64'hace); push("R11", 2, 7, 0);
    run_prog(); monitor();

    // signed overflow on add steers lt / ge
    clear_prog(8'h00);
    irm(4'h0, 64'h7fffffffffffffff); irm(4'h3, 64'd1);
    two(4'h6, 4'h0, 4'h0, 4'h3);
    two(4'h2, 4'h2, 4'h0, 4'h1); two(4'h2, 4'h5, 4'h0, 4'h2);
    push("R10", 0, 0, 10); push("R10", 2, 3, 64'h8000000000000000);
    push("R10", 2, 1, 0); push("R10", 2, 2, 64'h7fffffffffffffff);
    run_prog(); monitor();

    // no halt: run off the end of instruction memory
    clear_prog(8'h10);
    push("R6", 0, 0, 261); push("R6", 1, 0, 3); push("R6", 3, 0, MEMSZ);
    push("R12", 4, 0, 3);
    run_prog(); monitor();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule